// File: doc/BRIEF.md
# Dual-threshold thermal throttle controller

This block takes digitized junction-temperature samples and compares each one with two trip levels that are captured once, from calibration inputs, while reset is held. A sample at or above the lower level starts a hardware throttle. That path needs no software, so it acts as a fail-safe. A sample at or above the higher level raises a shutdown request. The request stays set until the next reset. The hardware throttle ends only when a later sample falls a set margin below the lower level, so a reading that sits near the threshold does not toggle the clock on and off.

Software can also force throttling through a plain request input. While either source is active, the core clock-enable follows a duty pattern set by a free-running counter. The enable is high while the count is below an on-count, and the count wraps after a period count. With no throttle active, the enable stays high and the core runs at full speed. A hot flag reports that throttling is active, whatever started it.

Samples arrive on a valid/ready stream. The block never applies back-pressure. Ready is low during reset and goes high at the first clock edge after reset is released. From then on, every cycle with valid high delivers one sample.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: While rst_n is low, the throttle level, critical level and hysteresis margin are loaded from cal_throttle, cal_critical and cal_margin on each clock edge. After release, clk_en=1, hot=0 and shutdown_req=0, and temp_ready is 0 until the first rising edge after release.
- R2: temp_ready is 1 on every cycle from the first edge after reset onward. A sample is taken at each edge where temp_valid and temp_ready are both 1, and never otherwise.
- R3: A taken sample with value >= throttle level sets the hardware throttle at that edge.
- R4: A taken sample clears the hardware throttle only if sample + margin < throttle level, with the sum computed without overflow. A sample between the two levels leaves the throttle state unchanged.
- R5: A taken sample with value >= critical level sets shutdown_req at that edge. shutdown_req then stays 1 until reset.
- R6: sw_throttle=1 makes the block throttle in the same cycle, whatever the temperature state.
- R7: The duty counter is 0 after reset. At each edge it goes to 0 if count+1 >= duty_period, and to count+1 otherwise, so a period of 0 or 1 holds it at 0. While throttling, clk_en = (count < duty_on).
- R8: While neither throttle source is active, clk_en is 1.
- R9: hot = hardware throttle OR sw_throttle.
- R10: Changes to the calibration inputs after reset release have no effect on the levels until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; calibration capture while low |
| temp_valid | input | 1 | Temperature sample valid |
| temp_ready | output | 1 | Sample accepted when high with valid |
| temp_data | input | TT_TEMP_W | Temperature sample code |
| cal_throttle | input | TT_TEMP_W | Calibration: throttle trip level |
| cal_critical | input | TT_TEMP_W | Calibration: shutdown trip level |
| cal_margin | input | TT_TEMP_W | Calibration: hysteresis margin |
| sw_throttle | input | 1 | Software throttle request |
| duty_on | input | CNT_W | Counts per period with clock enabled |
| duty_period | input | CNT_W | Duty counter period |
| clk_en | output | 1 | Core clock-enable |
| hot | output | 1 | Throttling active |
| shutdown_req | output | 1 | Latched shutdown request |

## Verification
The bench drives samples that sit exactly on the throttle level, and samples at the hysteresis bound where sample + margin equals the level. It checks that an off-by-one comparison would either start throttling one code late or release it one code early. It also tests sample values one below and at the critical level, and follows them with cool samples to catch a shutdown latch that clears. Duty periods of 0, 1 and a short period are used, along with an on-count at or above the period, to expose wrap and compare errors. Calibration inputs are changed after reset, and a sample placed between the old and new levels shows whether the block picked up the new values.

// File: rtl/tt_pkg.sv
package tt_pkg;
  parameter int TT_TEMP_W = 8;
  typedef logic [TT_TEMP_W-1:0] temp_t;
  typedef struct packed {
    temp_t thr;
    temp_t crit;
    temp_t margin;
  } trip_cfg_t;
endpackage

// File: rtl/tt_trip_regs.sv
module tt_trip_regs
  import tt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  trip_cfg_t cal,
  output trip_cfg_t trip
);
  // capture only while reset is held; frozen in normal operation
  always_ff @(posedge clk) begin
    if (!rst_n) trip <= cal;
  end
endmodule

// File: rtl/tt_temp_monitor.sv
module tt_temp_monitor
  import tt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take,
  input  temp_t     sample,
  input  trip_cfg_t trip,
  output logic      hw_thr,
  output logic      shut
);
  localparam int SW = TT_TEMP_W + 1;
  logic [SW-1:0] low_sum;
  logic          at_thr, below_band, at_crit;

  always_comb begin
    low_sum    = {1'b0, sample} + {1'b0, trip.margin};
    at_thr     = sample >= trip.thr;
    below_band = low_sum < {1'b0, trip.thr};
    at_crit    = sample >= trip.crit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_thr <= 1'b0;
      shut   <= 1'b0;
    end else if (take) begin
      if (at_thr)          hw_thr <= 1'b1;
      else if (below_band) hw_thr <= 1'b0;
      if (at_crit)         shut   <= 1'b1;
    end
  end
endmodule

// File: rtl/tt_duty_gen.sv
module tt_duty_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             throttle,
  input  logic [CNT_W-1:0] on_cnt,
  input  logic [CNT_W-1:0] period,
  output logic             clk_en
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   inc;

  always_comb inc = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (inc >= {1'b0, period}) cnt <= '0;
    else                           cnt <= inc[CNT_W-1:0];
  end

  always_comb clk_en = !throttle || (cnt < on_cnt);
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import tt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             temp_valid,
  output logic             temp_ready,
  input  temp_t            temp_data,
  input  temp_t            cal_throttle,
  input  temp_t            cal_critical,
  input  temp_t            cal_margin,
  input  logic             sw_throttle,
  input  logic [CNT_W-1:0] duty_on,
  input  logic [CNT_W-1:0] duty_period,
  output logic             clk_en,
  output logic             hot,
  output logic             shutdown_req
);
  trip_cfg_t cal, trip;
  logic      ready_q, take, hw_thr;

  always_comb begin
    cal.thr    = cal_throttle;
    cal.crit   = cal_critical;
    cal.margin = cal_margin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  always_comb begin
    temp_ready = ready_q;
    take       = temp_valid && ready_q;
    hot        = hw_thr || sw_throttle;
  end

  tt_trip_regs u_trip (.clk(clk), .rst_n(rst_n), .cal(cal), .trip(trip));

  tt_temp_monitor u_mon (
    .clk(clk), .rst_n(rst_n), .take(take), .sample(temp_data),
    .trip(trip), .hw_thr(hw_thr), .shut(shutdown_req)
  );

  tt_duty_gen #(.CNT_W(CNT_W)) u_duty (
    .clk(clk), .rst_n(rst_n), .throttle(hot), .on_cnt(duty_on),
    .period(duty_period), .clk_en(clk_en)
  );
endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import tt_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      temp_valid,
  input logic      temp_ready,
  input temp_t     temp_data,
  input logic      sw_throttle,
  input logic      clk_en,
  input logic      hot,
  input logic      shutdown_req,
  input trip_cfg_t trip
);
  p_shutdown_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> shutdown_req);
  p_crit_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && temp_ready && temp_data >= trip.crit) |=> shutdown_req);
  p_thr_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_valid && temp_ready && temp_data >= trip.thr) |=> hot);
  p_sw_hot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_throttle |-> hot);
  p_full_speed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hot |-> clk_en);
  p_ready_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    temp_ready |=> temp_ready);
  p_trip_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(trip));
endmodule

bind thermal_throttle_ctrl tt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
  .temp_data(temp_data), .sw_throttle(sw_throttle), .clk_en(clk_en),
  .hot(hot), .shutdown_req(shutdown_req), .trip(trip)
);

// File: tb/thermal_throttle_ctrl_bench.sv
module thermal_throttle_ctrl_bench;
  import tt_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0;
  logic temp_valid = 0, sw_throttle = 0;
  temp_t temp_data = '0, cal_throttle = '0, cal_critical = '0, cal_margin = '0;
  logic [CW-1:0] duty_on = '0, duty_period = '0;
  logic temp_ready, clk_en, hot, shutdown_req;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_throttle_ctrl #(.CNT_W(CW)) u_thermal_throttle_ctrl (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_ready(temp_ready),
    .temp_data(temp_data), .cal_throttle(cal_throttle), .cal_critical(cal_critical),
    .cal_margin(cal_margin), .sw_throttle(sw_throttle), .duty_on(duty_on),
    .duty_period(duty_period), .clk_en(clk_en), .hot(hot), .shutdown_req(shutdown_req)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  int m_thr, m_crit, m_mar, m_cnt;
  bit m_hw, m_sd, m_rdy;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_hot();
    return m_hw || sw_throttle;
  endfunction
  function automatic bit exp_en();
    return !exp_hot() || (m_cnt < int'(duty_on));
  endfunction

  task automatic check_all();
    chk(temp_ready == m_rdy, "R2", "temp_ready", temp_ready, m_rdy);
    chk(hot == exp_hot(), "R9", "hot", hot, exp_hot());
    chk(shutdown_req == m_sd, "R5", "shutdown_req", shutdown_req, m_sd);
    if (exp_hot()) chk(clk_en == exp_en(), "R7", "clk_en", clk_en, exp_en());
    else           chk(clk_en == 1'b1, "R8", "clk_en", clk_en, 1);
  endtask

  // inputs driven just after a falling edge; model advances one clock
  task automatic step(input bit v, input int d, input bit sw, input int on, input int per);
    bit nhw, nsd;
    int ncnt;
    temp_valid = v; temp_data = temp_t'(d); sw_throttle = sw;
    duty_on = CW'(on); duty_period = CW'(per);
    #1;
    check_all();
    nhw = m_hw; nsd = m_sd;
    if (v && m_rdy) begin
      if (d >= m_thr) nhw = 1;
      else if (d + m_mar < m_thr) nhw = 0;
      if (d >= m_crit) nsd = 1;
    end
    ncnt = (m_cnt + 1 >= per) ? 0 : m_cnt + 1;
    @(negedge clk);
    m_hw = nhw; m_sd = nsd; m_cnt = ncnt; m_rdy = 1;
  endtask

  task automatic do_reset(input int thr, input int crit, input int mar);
    @(negedge clk);
    rst_n = 0; temp_valid = 0; sw_throttle = 0;
    cal_throttle = temp_t'(thr); cal_critical = temp_t'(crit); cal_margin = temp_t'(mar);
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_thr = thr; m_crit = crit; m_mar = mar;
    m_hw = 0; m_sd = 0; m_cnt = 0; m_rdy = 0;
    #1;
    chk(clk_en == 1 && hot == 0 && shutdown_req == 0, "R1", "reset outputs",
        {clk_en, hot, shutdown_req}, 3'b100);
    chk(temp_ready == 0, "R1", "ready before first edge", temp_ready, 0);
  endtask

  initial begin
    void'($urandom(32'd12345));
    do_reset(100, 200, 10);
    step(0, 0, 0, 2, 5);
    chk(temp_ready == 1, "R1", "ready after first edge", temp_ready, 1);
    // R3 boundary
    step(1, 99, 0, 2, 5);
    chk(hot == 0, "R3", "99 below level", hot, 0);
    step(0, 150, 0, 2, 5);
    chk(hot == 0, "R2", "sample not taken without valid", hot, 0);
    step(1, 100, 0, 2, 5);
    chk(hot == 1, "R3", "100 at level", hot, 1);
    // R4 hysteresis band
    step(1, 95, 0, 2, 5);
    chk(hot == 1, "R4", "95 inside band", hot, 1);
    step(1, 90, 0, 2, 5);
    chk(hot == 1, "R4", "90 at band edge", hot, 1);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 2, 5);
    step(1, 89, 0, 2, 5);
    chk(hot == 0, "R4", "89 below band", hot, 0);
    // R6 software throttle and R7 duty
    for (int i = 0; i < 12; i++) step(0, 0, 1, 2, 5);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 1, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 1, 0, 1);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 9, 4);
    step(0, 0, 1, 3, 7);
    chk(hot == 1, "R6", "sw forces hot", hot, 1);
    // R10 calibration changes ignored
    cal_throttle = 8'd50; cal_critical = 8'd60; cal_margin = 8'd0;
    step(1, 70, 0, 2, 5);
    step(0, 0, 0, 2, 5);
    chk(hot == 0 && shutdown_req == 0, "R10", "new cal ignored",
        {hot, shutdown_req}, 0);
    // R5 critical latch
    step(1, 199, 0, 2, 5);
    chk(shutdown_req == 0, "R5", "199 below critical", shutdown_req, 0);
    step(1, 200, 0, 2, 5);
    chk(shutdown_req == 1, "R5", "200 at critical", shutdown_req, 1);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 2, 5);
    chk(shutdown_req == 1, "R5", "latch holds", shutdown_req, 1);
    // random phases with fresh calibration
    for (int ph = 0; ph < 3; ph++) begin
      int thr = 60 + $urandom_range(0, 80);
      int mar = $urandom_range(0, 20);
      do_reset(thr, thr + 40 + $urandom_range(0, 60), mar);
      for (int i = 0; i < 1500; i++) begin
        int d = (($urandom & 31) == 0) ? $urandom_range(0, 255)
                                       : thr - mar - 3 + $urandom_range(0, mar + 6);
        if (d < 0) d = 0;
        step($urandom_range(0, 1), d, ($urandom & 7) == 0,
             $urandom_range(0, 9), $urandom_range(0, 8));
      end
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule